// File: doc/BRIEF.md
# Chainable display RAM write steering

This block takes a stream of display data bytes and places their bits into a small display memory. The memory has four rows and is addressed by bit-column. It is meant for a segment LCD driver that can sit in a chain of identical devices. A host command loads a write pointer, and a second command sets a 2-bit subaddress counter. Each incoming byte then lands at the pointer position. The pointer moves on by an amount set by the multiplex drive mode.

Every device in a chain sees the same byte stream. A device keeps a bit only when its subaddress counter equals the 2-bit value strapped on its pins. When the pointer runs past the last column, it wraps to column 0 and the subaddress counter counts up. The stream therefore moves on to the next device in the chain with no further commands. This hand-over also works inside a single byte: bits beyond the last column go to column 0 under the next subaddress. A combinational read port returns the four row bits of any column for the downstream waveform logic.

Top module: `disp_ram_steer`

## Requirements
- R1: After an accepted byte the pointer advances by 8 when `mode`=0 (static), by 4 when `mode`=1 (two rows), by 3 when `mode`=2 (three rows) and by 2 when `mode`=3 (four rows).
- R2: A `ptr_load` pulse sets the pointer to `ptr_val`. The next accepted byte is stored starting at that column.
- R3: A `dev_sel` pulse loads the subaddress counter with `dev_val`.
- R4: Byte bit 7-i (i = 0..7, most significant bit first) is written to column pointer + i / N and to row i mod N, where N = `mode`+1 rows are active. In static mode only row 0 is written, across 8 columns. In three-row mode the ninth slot is left unused.
- R5: A bit is stored only when the subaddress that applies to it equals `strap`. On a mismatch nothing is written, but the pointer still advances exactly as for a stored byte.
- R6: When pointer + step reaches DEPTH, the pointer becomes pointer + step - DEPTH and the subaddress counter increments, wrapping from 3 to 0. Bits of the same byte whose column reaches DEPTH go to column - DEPTH and are matched against subaddress + 1.
- R7: A byte presented together with `abort` is discarded. The RAM, the pointer and the subaddress counter are all left unchanged.
- R8: After reset the pointer is 0, the subaddress counter is 0 and every RAM bit is 0.
- R9: `rd_bits` returns the four row bits of column `rd_col` without a clock cycle of delay, with bit r holding row r. A column at or beyond DEPTH reads as 0.
- R10: When `byte_vld` coincides with `ptr_load` or `dev_sel`, the command takes effect and the byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Display data byte |
| ptr_load | input | 1 | Load-pointer command strobe |
| ptr_val | input | PW | New pointer value |
| dev_sel | input | 1 | Device-select command strobe |
| dev_val | input | 2 | New subaddress counter value |
| mode | input | 2 | Drive mode: 0 static, 1/2/3 for two/three/four rows |
| strap | input | 2 | Hardware subaddress pins |
| abort | input | 1 | Early bus termination; discards the byte in the same cycle |
| rd_col | input | PW | Read column |
| rd_bits | output | 4 | Row bits of the read column |
| ptr_q | output | PW | Current pointer |
| sub_q | output | 2 | Current subaddress counter |

## Verification
The bench builds two instances with DEPTH=20 and PW=5, strapped to subaddresses 1 and 2. A depth of 20 is a multiple of neither 8 nor 3, so static and three-row streams split a byte across the wrap within a few writes. Handing a stream from one device to the next, landing on a device that is absent, and the counter wrapping from 3 to 0 are all reached within a short run. Both memories are swept column by column after each scenario.

// File: rtl/disp_ram_steer.sv
module disp_ram_steer #(
  parameter int DEPTH = 160,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_val,
  input  logic          dev_sel,
  input  logic [1:0]    dev_val,
  input  logic [1:0]    mode,
  input  logic [1:0]    strap,
  input  logic          abort,
  input  logic [PW-1:0] rd_col,
  output logic [3:0]    rd_bits,
  output logic [PW-1:0] ptr_q,
  output logic [1:0]    sub_q
);
  localparam logic [PW:0] DEP = (PW+1)'(DEPTH);

  logic [3:0] ram [DEPTH];
  logic [3:0] step;
  logic [PW:0] nxt;
  logic [PW-1:0] bcol [8];
  logic [1:0]    brow [8];
  logic [7:0]    ben;

  wire go  = byte_vld & ~ptr_load & ~dev_sel & ~abort;

  always_comb
    case (mode)
      2'd0:    step = 4'd8;
      2'd1:    step = 4'd4;
      2'd2:    step = 4'd3;
      default: step = 4'd2;
    endcase

  assign nxt = {1'b0, ptr_q} + (PW+1)'(step);
  wire ovf = nxt >= DEP;

  always_comb
    for (int i = 0; i < 8; i++) begin
      logic [2:0] off;
      logic [PW:0] raw;
      logic hi;
      case (mode)
        2'd0:    begin off = 3'(i);     brow[i] = 2'd0;        end
        2'd1:    begin off = 3'(i / 2); brow[i] = 2'(i % 2);   end
        2'd2:    begin off = 3'(i / 3); brow[i] = 2'(i % 3);   end
        default: begin off = 3'(i / 4); brow[i] = 2'(i % 4);   end
      endcase
      raw     = {1'b0, ptr_q} + (PW+1)'(off);
      hi      = raw >= DEP;
      bcol[i] = hi ? PW'(raw - DEP) : raw[PW-1:0];
      ben[i]  = go && ((sub_q + 2'(hi)) == strap);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr_q <= '0;
      sub_q <= '0;
      for (int c = 0; c < DEPTH; c++) ram[c] <= '0;
    end else begin
      if (ptr_load)  ptr_q <= ptr_val;
      else if (go)   ptr_q <= ovf ? PW'(nxt - DEP) : nxt[PW-1:0];
      if (dev_sel)        sub_q <= dev_val;
      else if (go && ovf) sub_q <= sub_q + 2'd1;
      for (int i = 0; i < 8; i++)
        if (ben[i]) ram[bcol[i]][brow[i]] <= byte_data[7-i];
    end

  assign rd_bits = ({1'b0, rd_col} < DEP) ? ram[rd_col] : 4'd0;
endmodule

// File: rtl/disp_ram_steer_chk.sv
module disp_ram_steer_chk #(
  parameter int DEPTH = 160,
  parameter int PW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic          ptr_load,
  input logic [PW-1:0] ptr_val,
  input logic          dev_sel,
  input logic [1:0]    dev_val,
  input logic [1:0]    mode,
  input logic          abort,
  input logic [PW-1:0] ptr_q,
  input logic [1:0]    sub_q
);
  function automatic int stp(logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 4 : (m == 2'd2) ? 3 : 2;
  endfunction

  wire acc = byte_vld && !ptr_load && !dev_sel && !abort;
  wire wrapv = (int'(ptr_q) + stp(mode)) >= DEPTH;
  wire [PW+3:0] nexp = (PW+4)'(wrapv ? int'(ptr_q) + stp(mode) - DEPTH
                                     : int'(ptr_q) + stp(mode));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && int'(ptr_q) < DEPTH |=> ptr_q == $past(nexp[PW-1:0]));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr_q == $past(ptr_val));
  p_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel |=> sub_q == $past(dev_val));
  p_wrap_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wrapv |=> sub_q == $past(sub_q) + 2'd1);
  p_nowrap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_sel && !(acc && wrapv) |=> $stable(sub_q));
  p_abort_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !ptr_load |=> $stable(ptr_q));
  p_cmd_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && dev_sel && !ptr_load |=> $stable(ptr_q));
endmodule

bind disp_ram_steer disp_ram_steer_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .ptr_load(ptr_load),
  .ptr_val(ptr_val), .dev_sel(dev_sel), .dev_val(dev_val), .mode(mode),
  .abort(abort), .ptr_q(ptr_q), .sub_q(sub_q));

// File: tb/disp_ram_steer_test.sv
module disp_ram_steer_test;
  localparam int D = 20;
  localparam int PW = 5;

  logic clk = 0, rst_n = 0;
  logic byte_vld = 0, ptr_load = 0, dev_sel = 0, abort = 0;
  logic [7:0] byte_data = 0;
  logic [PW-1:0] ptr_val = 0, rd_col = 0;
  logic [1:0] dev_val = 0, mode = 0;
  logic [3:0] rd_a, rd_b;
  logic [PW-1:0] ptr_a, ptr_b;
  logic [1:0] sub_a, sub_b;

  int errors = 0, checks = 0;
  logic [3:0] ref_ram [2][D];
  int ref_ptr = 0, ref_sub = 0;
  int strp [2] = '{1, 2};

  always #5 clk = ~clk;

  disp_ram_steer #(.DEPTH(D), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .dev_sel(dev_sel), .dev_val(dev_val),
    .mode(mode), .strap(2'd1), .abort(abort), .rd_col(rd_col),
    .rd_bits(rd_a), .ptr_q(ptr_a), .sub_q(sub_a));
  disp_ram_steer #(.DEPTH(D), .PW(PW)) uut_b (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .dev_sel(dev_sel), .dev_val(dev_val),
    .mode(mode), .strap(2'd2), .abort(abort), .rd_col(rd_col),
    .rd_bits(rd_b), .ptr_q(ptr_b), .sub_q(sub_b));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ref_byte(logic [7:0] b);
    int rows = int'(mode) + 1;
    int st = (mode == 0) ? 8 : (mode == 1) ? 4 : (mode == 2) ? 3 : 2;
    for (int i = 0; i < 8; i++) begin
      int c = ref_ptr + i / rows;
      int s = ref_sub;
      if (c >= D) begin c -= D; s = (s + 1) % 4; end
      for (int k = 0; k < 2; k++)
        if (s == strp[k]) ref_ram[k][c][i % rows] = b[7-i];
    end
    ref_ptr += st;
    if (ref_ptr >= D) begin ref_ptr -= D; ref_sub = (ref_sub + 1) % 4; end
  endtask

  task automatic do_load(int p);
    ptr_load = 1; ptr_val = PW'(p); tick(); ptr_load = 0; ref_ptr = p;
  endtask

  task automatic do_sel(int s);
    dev_sel = 1; dev_val = 2'(s); tick(); dev_sel = 0; ref_sub = s;
  endtask

  task automatic do_byte(logic [7:0] b, bit ab);
    byte_vld = 1; byte_data = b; abort = ab; tick();
    byte_vld = 0; abort = 0;
    if (!ab) ref_byte(b);
  endtask

  task automatic compare(string tag);
    chk({tag, " R1 R2 ptr"}, int'(ptr_a), ref_ptr);
    chk({tag, " R3 R6 sub"}, int'(sub_a), ref_sub);
    chk({tag, " R1 ptr dev1"}, int'(ptr_b), ref_ptr);
    for (int c = 0; c < D; c++) begin
      rd_col = PW'(c); #1;
      chk({tag, " R4 R5 R9 ram dev0"}, int'(rd_a), int'(ref_ram[0][c]));
      chk({tag, " R4 R5 R9 ram dev1"}, int'(rd_b), int'(ref_ram[1][c]));
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) for (int c = 0; c < D; c++) ref_ram[k][c] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R8 reset");
    rd_col = PW'(D + 3); #1;
    chk("R9 out of range column", int'(rd_a), 0);

    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      do_sel(1);
      do_load(D - 3);
      for (int j = 0; j < 5; j++) do_byte(8'($urandom), 0);
      compare($sformatf("R6 handover mode%0d", m));
    end

    mode = 2'd2; do_sel(3); do_load(D - 4);
    for (int j = 0; j < 4; j++) do_byte(8'hFF, 0);
    compare("R5 R6 absent device then wrap 3->0");

    mode = 2'd0; do_sel(1); do_load(4);
    do_byte(8'hA5, 1);
    compare("R7 abort discards");
    do_load(4);
    byte_vld = 1; byte_data = 8'h3C; ptr_load = 1; ptr_val = PW'(9); tick();
    byte_vld = 0; ptr_load = 0; ref_ptr = 9;
    compare("R10 load wins over byte");
    byte_vld = 1; byte_data = 8'hC3; dev_sel = 1; dev_val = 2'd2; tick();
    byte_vld = 0; dev_sel = 0; ref_sub = 2;
    compare("R10 select wins over byte");

    for (int n = 0; n < 300; n++) begin
      int a = int'($urandom % 10);
      if (a == 0) mode = 2'($urandom);
      else if (a == 1) do_sel(int'($urandom % 4));
      else if (a == 2) do_load(int'($urandom % D));
      else if (a == 3) begin do_byte(8'($urandom), 1); do_load(int'($urandom % D)); end
      else do_byte(8'($urandom), 0);
      if (n % 50 == 49) compare("R1 R4 R5 R6 random");
    end
    compare("R4 R6 random final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule